// File: doc/BRIEF.md
# Hysteresis Integrating Input Debouncer

This block cleans up a noisy single-bit input, such as a push button or a relay contact, for use in a clocked design. The raw level is first brought into the clock domain by a chain of flip-flops. After that, a bounded up/down counter integrates it: on every cycle where the sample strobe is high, the count rises by one if the synchronised level is high and falls by one if it is low. The count never drops below zero and never exceeds a configured ceiling.

The clean output is a registered level with hysteresis. It turns on when the count reaches an upper level and turns off when the count falls to a lower level. Between the two levels it keeps its previous value. A burst of short highs cannot turn the output on unless it builds the count up to the upper level. Once the output is on, short lows only take a few steps off the count and leave the output on. The current count is available as a port so the level of evidence can be observed.

Top module: `glint_integrator`

## Requirements
- R1: While reset is high and on the first cycle after it, the count reads 0 and the output reads 0.
- R2: On a strobe cycle where the synchronised level is 1 and the count is below CNT_MAX, the count rises by exactly one.
- R3: On a strobe cycle where the synchronised level is 0, the count falls by one if it is above 0 and stays at 0 otherwise.
- R4: On a strobe cycle where the synchronised level is 1 and the count equals CNT_MAX, the count stays at CNT_MAX, and the count never exceeds CNT_MAX.
- R5: The output becomes 1 on the same clock edge at which the count reaches ON_LEVEL or above, and it is 1 whenever the count is at least ON_LEVEL.
- R6: The output becomes 0 on the same clock edge at which the count reaches OFF_LEVEL or below, and it is 0 whenever the count is at most OFF_LEVEL.
- R7: While the count lies strictly between OFF_LEVEL and ON_LEVEL, the output keeps its previous value.
- R8: On a cycle with the strobe low, neither the count nor the output changes, whatever the raw input does.
- R9: The raw input passes through two flip-flops before it is integrated. A strobe at clock edge k uses the raw value captured at edge k-2, so a change on the raw input cannot move the count at the first two edges after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | Sample strobe; the count and output update only on cycles where it is high |
| raw_in | input | 1 | Noisy asynchronous input level |
| level_out | output | 1 | Debounced level with hysteresis |
| level_count | output | $clog2(CNT_MAX+1) | Current integrator count |

## Verification
The bench builds the block with CNT_MAX = 6, ON_LEVEL = 5 and OFF_LEVEL = 2, so a gap of two counts separates the switching levels and the ceiling lies one step above the on level. With these values, saturation, the floor, both switching points and the hold band between them can all be reached within a few strobes. Short glitch runs can then be placed inside the hold band to show that they are absorbed. The strobe is driven both at a fixed spacing and at random, and the raw input toggles on cycles without a strobe, so the two-stage input delay and the rule that nothing changes without a strobe are both exercised.

// File: rtl/glint_pkg.sv
package glint_pkg;
   // Number of bits needed to hold values 0..maxv
   function automatic int cnt_bits(input int maxv);
      return (maxv < 1) ? 1 : $clog2(maxv + 1);
   endfunction
endpackage

// File: rtl/glint_sync.sv
module glint_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic d_sync
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b0;
               else     chain_q[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[g] <= 1'b0;
               else     chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/glint_counter.sv
module glint_counter #(
   parameter int CNT_MAX = 9,
   parameter int CW      = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_en,
   input  logic          level,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_nxt
);
   localparam logic [CW-1:0] TOP  = CW'(CNT_MAX);
   localparam logic [CW-1:0] ONE  = CW'(1);
   localparam logic [CW-1:0] ZERO = '0;

   // R2 R3 R4: bounded up/down step
   always_comb begin
      cnt_nxt = cnt_q;
      if (step_en) begin
         if (level) begin
            if (cnt_q != TOP) cnt_nxt = cnt_q + ONE;
         end else begin
            if (cnt_q != ZERO) cnt_nxt = cnt_q - ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= ZERO;
      else     cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/glint_hyst.sv
module glint_hyst #(
   parameter int ON_LEVEL  = 9,
   parameter int OFF_LEVEL = 0,
   parameter int CW        = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cnt_nxt,
   output logic          out_q
);
   localparam logic [CW-1:0] ON_V  = CW'(ON_LEVEL);
   localparam logic [CW-1:0] OFF_V = CW'(OFF_LEVEL);
   logic out_nxt;

   // R5 R6 R7: switch at the levels, hold in between
   always_comb begin
      out_nxt = out_q;
      if (cnt_nxt >= ON_V)       out_nxt = 1'b1;
      else if (cnt_nxt <= OFF_V) out_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) out_q <= 1'b0;
      else     out_q <= out_nxt;
   end
endmodule

// File: rtl/glint_integrator.sv
module glint_integrator #(
   parameter int CNT_MAX     = 9,
   parameter int ON_LEVEL    = 9,
   parameter int OFF_LEVEL   = 0,
   parameter int SYNC_STAGES = 2,
   localparam int CW = glint_pkg::cnt_bits(CNT_MAX)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sample_tick,
   input  logic          raw_in,
   output logic          level_out,
   output logic [CW-1:0] level_count
);
   generate
      if (CNT_MAX < 1) begin : g_bad_max
         $error("CNT_MAX must be at least 1");
      end
      if (ON_LEVEL > CNT_MAX || ON_LEVEL < 1) begin : g_bad_on
         $error("ON_LEVEL must lie in 1..CNT_MAX");
      end
      if (OFF_LEVEL < 0 || OFF_LEVEL >= ON_LEVEL) begin : g_bad_off
         $error("OFF_LEVEL must lie in 0..ON_LEVEL-1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          lvl_sync;
   logic [CW-1:0] cnt_nxt;

   // R9: input synchroniser
   glint_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst(rst), .d_async(raw_in), .d_sync(lvl_sync)
   );

   glint_counter #(.CNT_MAX(CNT_MAX), .CW(CW)) cnt_i (
      .clk(clk), .rst(rst), .step_en(sample_tick), .level(lvl_sync),
      .cnt_q(level_count), .cnt_nxt(cnt_nxt)
   );

   glint_hyst #(.ON_LEVEL(ON_LEVEL), .OFF_LEVEL(OFF_LEVEL), .CW(CW)) hyst_i (
      .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .out_q(level_out)
   );
endmodule

// File: rtl/glint_integrator_chk.sv
module glint_integrator_chk #(
   parameter int CNT_MAX   = 9,
   parameter int ON_LEVEL  = 9,
   parameter int OFF_LEVEL = 0,
   parameter int CW        = 4
) (
   input logic          clk,
   input logic          rst,
   input logic          sample_tick,
   input logic          level_out,
   input logic [CW-1:0] level_count
);
   a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
      int'(level_count) <= CNT_MAX);

   a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
      sample_tick |=> (int'(level_count) - int'($past(level_count)) <= 1) &&
                      (int'($past(level_count)) - int'(level_count) <= 1));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !sample_tick |=> $stable(level_count) && $stable(level_out));

   a_r5_on_region: assert property (@(posedge clk) disable iff (rst)
      (int'(level_count) >= ON_LEVEL) |-> level_out);

   a_r6_off_region: assert property (@(posedge clk) disable iff (rst)
      (int'(level_count) <= OFF_LEVEL) |-> !level_out);

   a_r7_rise_only_at_on: assert property (@(posedge clk) disable iff (rst)
      $rose(level_out) |-> int'(level_count) >= ON_LEVEL);

   a_r7_fall_only_at_off: assert property (@(posedge clk) disable iff (rst)
      $fell(level_out) |-> int'(level_count) <= OFF_LEVEL);
endmodule

bind glint_integrator glint_integrator_chk #(
   .CNT_MAX(CNT_MAX), .ON_LEVEL(ON_LEVEL), .OFF_LEVEL(OFF_LEVEL), .CW(CW)
) chk_i (
   .clk(clk), .rst(rst), .sample_tick(sample_tick),
   .level_out(level_out), .level_count(level_count)
);

// File: tb/glint_integrator_tb_top.sv
module glint_integrator_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int MAXV = 6;
   localparam int ONV  = 5;
   localparam int OFFV = 2;
   localparam int W    = $clog2(MAXV + 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic raw = 1'b0;
   logic out_w;
   logic [W-1:0] cnt_w;

   int checks = 0;
   int fails  = 0;

   // reference model state
   int m_s1 = 0, m_s2 = 0, m_cnt = 0, m_out = 0;
   string cnt_tag = "R1", out_tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   glint_integrator #(.CNT_MAX(MAXV), .ON_LEVEL(ONV), .OFF_LEVEL(OFFV)) dut_i (
      .clk(clk), .rst(rst), .sample_tick(tick), .raw_in(raw),
      .level_out(out_w), .level_count(cnt_w)
   );

   always @(posedge clk) begin
      int prev_out;
      prev_out = m_out;
      if (rst) begin
         m_s1 = 0; m_s2 = 0; m_cnt = 0; m_out = 0;
         cnt_tag = "R1"; out_tag = "R1";
      end else begin
         if (tick) begin
            if (m_s2 == 1) begin
               if (m_cnt < MAXV) begin m_cnt++; cnt_tag = "R2"; end
               else cnt_tag = "R4";
            end else begin
               if (m_cnt > 0) m_cnt--;
               cnt_tag = "R3";
            end
            if (m_cnt >= ONV) m_out = 1;
            else if (m_cnt <= OFFV) m_out = 0;
            if (prev_out == 0 && m_out == 1) out_tag = "R5";
            else if (prev_out == 1 && m_out == 0) out_tag = "R6";
            else out_tag = "R7";
         end else begin
            cnt_tag = "R8"; out_tag = "R8";
         end
         m_s2 = m_s1;
         m_s1 = int'(raw);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      check(cnt_tag, int'(cnt_w), m_cnt);
      check(out_tag, int'(out_w), m_out);
   end

   task automatic drive(input logic r, input logic t, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         raw  = r;
         tick = t;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(cnt_w), 0);
      check("R1", int'(out_w), 0);
      @(negedge clk); rst = 1'b0;

      // R9: raw rises with a strobe every cycle; two edges pass before it counts
      raw = 1'b1; tick = 1'b1;
      @(negedge clk); check("R9", int'(cnt_w), 0);
      @(negedge clk); check("R9", int'(cnt_w), 0);
      @(negedge clk); check("R9", int'(cnt_w), 1);

      // R2 R4 R5: climb to the ceiling and stay there
      drive(1'b1, 1'b1, 10);
      check("R4", int'(cnt_w), MAXV);
      check("R5", int'(out_w), 1);

      // R8: raw toggles with no strobe
      for (int i = 0; i < 8; i++) drive(i[0], 1'b0, 1);
      @(negedge clk);
      check("R8", int'(cnt_w), MAXV);

      // R7: short low glitches leave the output on
      drive(1'b1, 1'b1, 4);
      drive(1'b0, 1'b1, 2);
      drive(1'b1, 1'b1, 2);
      drive(1'b0, 1'b1, 3);
      drive(1'b1, 1'b0, 3);
      check("R7", int'(out_w), 1);

      // R3 R6: sustained low drains the count to the floor
      drive(1'b0, 1'b1, 12);
      check("R3", int'(cnt_w), 0);
      check("R6", int'(out_w), 0);

      // R7: isolated short highs never set the output
      for (int i = 0; i < 6; i++) begin
         drive(1'b1, 1'b1, 2);
         drive(1'b0, 1'b1, 2);
      end
      check("R7", int'(out_w), 0);

      // strobe every other cycle
      for (int i = 0; i < 40; i++) begin
         drive(i < 24, 1'b1, 1);
         drive(i < 24, 1'b0, 1);
      end

      // random level and strobe
      for (int i = 0; i < 3000; i++)
         drive(($urandom % 4) != 0 ? (i % 200 < 100) : ~(i % 200 < 100),
               ($urandom % 3) != 0, 1);

      // R1: reset mid-run
      drive(1'b1, 1'b1, 12);
      rst = 1'b1;
      @(negedge clk);
      check("R1", int'(cnt_w), 0);
      check("R1", int'(out_w), 0);
      rst = 1'b0;
      drive(1'b0, 1'b0, 3);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule